// File: doc/BRIEF.md
# Card Slot Access Strobe Sequencer

This block carries out a single read or write access to a PC-card style slot. Timing comes from a per-window option word that is presented with the request. When a request is accepted, the block latches the address and drives it onto the slot. It then counts a programmed setup interval and asserts one strobe for a programmed number of clocks. The card may stretch that strobe by holding its wait line. After the strobe, the address stays on the bus for a programmed hold interval. A one-clock done pulse closes the access.

The window options also set several other things. The region code decides whether the access uses the I/O strobes or the memory output-enable and write-enable strobes, and whether the DMA terminal-count line goes out with the strobe. A slot bit and a port-width bit are latched and presented with the address. Before an access starts, the block checks it. An invalid window, a write to a write-protected window, a reserved setup code or a reserved region code each end the request with a one-clock error pulse, and no bus activity follows. Requests are only taken while the sequencer is idle.

Top module: `cardStrobeSeq`

## Requirements
- R1: After reset, all four strobes, terminal count, address enable, done and the error pulse are low.
- R2: A request taken at a clock edge drives addrEn with no strobe for exactly S clocks before the strobe starts, where S is the 4-bit setup code, 1 to 15.
- R3: With the wait line low, the strobe stays asserted for exactly L clocks, where L is the 5-bit length code. Code 0 means 32 clocks.
- R4: Each strobe-phase clock in which cardWait is sampled high adds exactly one clock to the strobe phase.
- R5: After the strobe, addrEn stays high with no strobe for exactly H clocks, where H is the 4-bit hold code, 0 to 15. The next clock has done high for one cycle with addrEn low, and the clock after that is idle.
- R6: Region code 3 (binary 011) uses ioRdStb for reads and ioWrStb for writes. Region codes 0, 2, 4 and 5 use memRdStb (output enable) for reads and memWrStb (write enable) for writes. Exactly one strobe is high in each strobe clock.
- R7: Under region 5, termCount is high in every strobe clock. Under region 4, termCount is high in every strobe clock only when dmaLast was high with the request. In all other cases termCount stays low.
- R8: A write to a window with optWriteProt set gives errPulse high for one clock in the clock after the request. No address enable, strobe or done follows. A read from the same window runs normally.
- R9: A request with optValid low is rejected in the same way as R8.
- R10: A setup code of 0, or a region code of 1, 6 or 7, is rejected in the same way as R8.
- R11: While addrEn is high, cardAddr equals the requested address, and slotB and port16 equal the latched optSlot and optWide.
- R12: reqValid while an access is in progress has no effect. The address stays unchanged, and exactly one done ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request, taken while idle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Access address |
| optValid | input | 1 | Window valid bit |
| optWriteProt | input | 1 | Window write-protect bit |
| optSetup | input | 4 | Setup clocks, 0 reserved |
| optStrobeLen | input | 5 | Strobe clocks, 0 means 32 |
| optHold | input | 4 | Hold clocks |
| optWide | input | 1 | Port width: 0 8-bit, 1 16-bit |
| optRegion | input | 3 | Region code |
| optSlot | input | 1 | 0 slot A, 1 slot B |
| dmaLast | input | 1 | DMA controller flags the last transfer |
| cardWait | input | 1 | Card wait, stretches the strobe |
| cardAddr | output | ADDR_W | Latched access address |
| addrEn | output | 1 | Address driven onto slot |
| slotB | output | 1 | Access targets slot B |
| port16 | output | 1 | 16-bit port access |
| memRdStb | output | 1 | Memory output-enable strobe |
| memWrStb | output | 1 | Memory write-enable strobe |
| ioRdStb | output | 1 | I/O read strobe |
| ioWrStb | output | 1 | I/O write strobe |
| termCount | output | 1 | DMA terminal count |
| done | output | 1 | Access complete pulse |
| errPulse | output | 1 | Rejected request pulse |

## Verification
The bench builds the block with an 8-bit address. This keeps addresses simple to follow and leaves every timing field at full width. Because of that, the bench can sweep all 15 setup codes, all 32 strobe-length codes including the wrapped zero, and all 16 hold codes. It can also sweep every region code against both directions and both values of the DMA-last flag. Wait bursts of several lengths and a request that arrives in the middle of an access exercise the stretch and ignore paths.

// File: rtl/cardStrobePkg.sv
package cardStrobePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE,
    ST_REJECT
  } seqState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;
    logic loadStrobe;
    logic loadHold;
    logic decr;
  } seqCtl_t;

  localparam logic [2:0] RGN_COMMON = 3'd0;
  localparam logic [2:0] RGN_ATTR   = 3'd2;
  localparam logic [2:0] RGN_IO     = 3'd3;
  localparam logic [2:0] RGN_DMA    = 3'd4;
  localparam logic [2:0] RGN_DMAEND = 3'd5;

  localparam int SETUP_W = 4;
  localparam int LEN_W   = 5;
  localparam int HOLD_W  = 4;
  localparam int CNT_W   = (LEN_W > SETUP_W) ? LEN_W : SETUP_W;

endpackage

// File: rtl/cardStrobeData.sv
module cardStrobeData
  import cardStrobePkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                optValid,
  input  logic                optWriteProt,
  input  logic [SETUP_W-1:0]  optSetup,
  input  logic [LEN_W-1:0]    optStrobeLen,
  input  logic [HOLD_W-1:0]   optHold,
  input  logic                optWide,
  input  logic [2:0]          optRegion,
  input  logic                optSlot,
  input  logic                dmaLast,
  output logic                reqReject,
  output logic                cntZero,
  output logic                holdZero,
  output logic [ADDR_W-1:0]   addrQ,
  output logic                writeQ,
  output logic                ioQ,
  output logic                slotQ,
  output logic                wideQ,
  output logic                tcQ
);

  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  lenQ;
  logic [HOLD_W-1:0] holdQ;
  logic              regionOk;

  always_comb begin
    unique case (optRegion)
      RGN_COMMON, RGN_ATTR, RGN_IO, RGN_DMA, RGN_DMAEND: regionOk = 1'b1;
      default: regionOk = 1'b0;
    endcase
  end

  assign reqReject = !optValid || (optWriteProt && reqWrite) ||
                     (optSetup == '0) || !regionOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      lenQ   <= '0;
      holdQ  <= '0;
      addrQ  <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
      slotQ  <= 1'b0;
      wideQ  <= 1'b0;
      tcQ    <= 1'b0;
    end else if (ctl.capture) begin
      cnt    <= CNT_W'(optSetup - SETUP_W'(1));
      lenQ   <= optStrobeLen;
      holdQ  <= optHold;
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      ioQ    <= (optRegion == RGN_IO);
      slotQ  <= optSlot;
      wideQ  <= optWide;
      tcQ    <= (optRegion == RGN_DMAEND) || ((optRegion == RGN_DMA) && dmaLast);
    end else if (ctl.loadStrobe) begin
      // length code 0 wraps to 31, i.e. 32 strobe clocks
      cnt <= CNT_W'(lenQ - LEN_W'(1));
    end else if (ctl.loadHold) begin
      cnt <= CNT_W'(holdQ - HOLD_W'(1));
    end else if (ctl.decr) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero  = (cnt == '0);
  assign holdZero = (holdQ == '0);

endmodule

// File: rtl/cardStrobeCtrl.sv
module cardStrobeCtrl
  import cardStrobePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqReject,
  input  logic    cardWait,
  input  logic    cntZero,
  input  logic    holdZero,
  output seqCtl_t ctl,
  output logic    addrPhase,
  output logic    strobePhase,
  output logic    donePulse,
  output logic    rejectPulse
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqReject) begin
            stateNxt = ST_REJECT;
          end else begin
            ctl.capture = 1'b1;
            stateNxt    = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          ctl.loadStrobe = 1'b1;
          stateNxt       = ST_STROBE;
        end else begin
          ctl.decr = 1'b1;
        end
      end
      ST_STROBE: begin
        if (!cardWait) begin
          if (cntZero) begin
            if (holdZero) begin
              stateNxt = ST_DONE;
            end else begin
              ctl.loadHold = 1'b1;
              stateNxt     = ST_HOLD;
            end
          end else begin
            ctl.decr = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cntZero) stateNxt = ST_DONE;
        else         ctl.decr = 1'b1;
      end
      ST_DONE:   stateNxt = ST_IDLE;
      ST_REJECT: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign addrPhase   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign strobePhase = (state == ST_STROBE);
  assign donePulse   = (state == ST_DONE);
  assign rejectPulse = (state == ST_REJECT);

endmodule

// File: rtl/cardStrobeSeq.sv
module cardStrobeSeq
  import cardStrobePkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              optValid,
  input  logic              optWriteProt,
  input  logic [3:0]        optSetup,
  input  logic [4:0]        optStrobeLen,
  input  logic [3:0]        optHold,
  input  logic              optWide,
  input  logic [2:0]        optRegion,
  input  logic              optSlot,
  input  logic              dmaLast,
  input  logic              cardWait,
  output logic [ADDR_W-1:0] cardAddr,
  output logic              addrEn,
  output logic              slotB,
  output logic              port16,
  output logic              memRdStb,
  output logic              memWrStb,
  output logic              ioRdStb,
  output logic              ioWrStb,
  output logic              termCount,
  output logic              done,
  output logic              errPulse
);

  seqCtl_t ctl;
  logic reqReject, cntZero, holdZero;
  logic writeQ, ioQ, slotQ, wideQ, tcQ;
  logic addrPhase, strobePhase;

  cardStrobeData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqAddr(reqAddr),
    .optValid(optValid), .optWriteProt(optWriteProt),
    .optSetup(optSetup), .optStrobeLen(optStrobeLen), .optHold(optHold),
    .optWide(optWide), .optRegion(optRegion), .optSlot(optSlot),
    .dmaLast(dmaLast),
    .reqReject(reqReject), .cntZero(cntZero), .holdZero(holdZero),
    .addrQ(cardAddr), .writeQ(writeQ), .ioQ(ioQ), .slotQ(slotQ),
    .wideQ(wideQ), .tcQ(tcQ)
  );

  cardStrobeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReject(reqReject),
    .cardWait(cardWait), .cntZero(cntZero), .holdZero(holdZero),
    .ctl(ctl), .addrPhase(addrPhase), .strobePhase(strobePhase),
    .donePulse(done), .rejectPulse(errPulse)
  );

  assign addrEn    = addrPhase;
  assign slotB     = slotQ;
  assign port16    = wideQ;
  assign memRdStb  = strobePhase && !ioQ && !writeQ;
  assign memWrStb  = strobePhase && !ioQ &&  writeQ;
  assign ioRdStb   = strobePhase &&  ioQ && !writeQ;
  assign ioWrStb   = strobePhase &&  ioQ &&  writeQ;
  assign termCount = strobePhase && !ioQ && tcQ;

endmodule

// File: rtl/cardStrobeSeqChk.sv
module cardStrobeSeqChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cardWait,
  input logic [ADDR_W-1:0] cardAddr,
  input logic              addrEn,
  input logic              memRdStb,
  input logic              memWrStb,
  input logic              ioRdStb,
  input logic              ioWrStb,
  input logic              termCount,
  input logic              done,
  input logic              errPulse
);

  logic anyStb;
  assign anyStb = memRdStb || memWrStb || ioRdStb || ioWrStb;

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdStb, memWrStb, ioRdStb, ioWrStb}));

  p_strobe_under_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> addrEn);

  p_wait_stretch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && cardWait) |=> anyStb);

  p_tc_mem_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> (memRdStb || memWrStb));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_no_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !addrEn);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!addrEn && !anyStb && !done));

  p_err_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addrEn && $past(addrEn)) |-> $stable(cardAddr));

endmodule

bind cardStrobeSeq cardStrobeSeqChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cardWait(cardWait), .cardAddr(cardAddr),
  .addrEn(addrEn), .memRdStb(memRdStb), .memWrStb(memWrStb),
  .ioRdStb(ioRdStb), .ioWrStb(ioWrStb), .termCount(termCount),
  .done(done), .errPulse(errPulse)
);

// File: tb/cardStrobeSeq_test.sv
module cardStrobeSeq_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic optValid = 1, optWriteProt = 0;
  logic [3:0] optSetup = 4'd1, optHold = '0;
  logic [4:0] optStrobeLen = 5'd1;
  logic optWide = 0, optSlot = 0, dmaLast = 0, cardWait = 0;
  logic [2:0] optRegion = '0;
  logic [AW-1:0] cardAddr;
  logic addrEn, slotB, port16, memRdStb, memWrStb, ioRdStb, ioWrStb;
  logic termCount, done, errPulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cardStrobeSeq #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .optValid(optValid), .optWriteProt(optWriteProt),
    .optSetup(optSetup), .optStrobeLen(optStrobeLen), .optHold(optHold),
    .optWide(optWide), .optRegion(optRegion), .optSlot(optSlot),
    .dmaLast(dmaLast), .cardWait(cardWait), .cardAddr(cardAddr),
    .addrEn(addrEn), .slotB(slotB), .port16(port16), .memRdStb(memRdStb),
    .memWrStb(memWrStb), .ioRdStb(ioRdStb), .ioWrStb(ioWrStb),
    .termCount(termCount), .done(done), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runAccess(input int s, input int l, input int h, input int rgn,
                           input bit wr, input bit wp, input bit vld, input bit dl,
                           input bit slt, input bit wd, input int addr,
                           input int waitN, input bit intrude, input string tag);
    bit rgnOk = (rgn == 0) || (rgn == 2) || (rgn == 3) || (rgn == 4) || (rgn == 5);
    bit expOk = vld && !(wp && wr) && (s != 0) && rgnOk;
    int expL = (l == 0) ? 32 : l;
    bit isIo = (rgn == 3);
    bit expTc = !isIo && ((rgn == 5) || ((rgn == 4) && dl));
    logic [3:0] expVec = isIo ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000);
    int sCnt = 0, stCnt = 0, hCnt = 0, kindBad = 0, tcBad = 0, sideBad = 0, cyc = 0;
    bit sawDone = 0;
    @(negedge clk);
    optSetup = 4'(s); optStrobeLen = 5'(l); optHold = 4'(h); optRegion = 3'(rgn);
    reqWrite = wr; optWriteProt = wp; optValid = vld; dmaLast = dl;
    optSlot = slt; optWide = wd; reqAddr = AW'(addr); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!expOk) begin
      check(errPulse && !addrEn, tag, {errPulse, addrEn}, 2);
      @(negedge clk);
      check(!errPulse && !done && !addrEn, tag, {errPulse, done, addrEn}, 0);
      return;
    end
    while (cyc < 200 && !done) begin
      if (memRdStb || memWrStb || ioRdStb || ioWrStb) begin
        if ({memRdStb, memWrStb, ioRdStb, ioWrStb} != expVec) kindBad++;
        if (termCount != expTc) tcBad++;
        cardWait = (stCnt < waitN);
        stCnt++;
      end else begin
        cardWait = 1'b0;
        if (termCount) tcBad++;
        if (addrEn) begin
          if (stCnt == 0) sCnt++; else hCnt++;
        end
      end
      if (addrEn && (cardAddr != AW'(addr) || slotB != slt || port16 != wd)) sideBad++;
      if (intrude && stCnt == 2) begin reqValid = 1'b1; reqAddr = ~AW'(addr); end
      else reqValid = 1'b0;
      cyc++;
      @(negedge clk);
    end
    cardWait = 1'b0;
    reqValid = 1'b0;
    sawDone = done;
    check(sCnt == s, "R2 setup clocks", sCnt, s);
    check(stCnt == expL + waitN, (waitN > 0) ? "R4 strobe with wait" : "R3 strobe clocks",
          stCnt, expL + waitN);
    check(hCnt == h, "R5 hold clocks", hCnt, h);
    check(sawDone && !addrEn, "R5 done pulse", {sawDone, addrEn}, 2);
    check(kindBad == 0, "R6 strobe select", kindBad, 0);
    check(tcBad == 0, "R7 terminal count", tcBad, 0);
    check(sideBad == 0, intrude ? "R12 request ignored" : "R11 address side", sideBad, 0);
    @(negedge clk);
    check(!done && !addrEn && !errPulse, intrude ? "R12 single done" : "R5 idle after done",
          {done, addrEn, errPulse}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!(memRdStb | memWrStb | ioRdStb | ioWrStb | termCount | addrEn | done | errPulse),
          "R1 reset outputs", {memRdStb, memWrStb, ioRdStb, ioWrStb, termCount, addrEn, done, errPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!addrEn && !done && !errPulse, "R1 idle after reset", {addrEn, done, errPulse}, 0);

    for (int s = 1; s < 16; s++)
      runAccess(s, 3, 2, 0, s[0], 0, 1, 0, s[1], s[2], s * 7, 0, 0, "R2");
    for (int l = 0; l < 32; l++)
      runAccess(1 + (l % 3), l, l % 4, (l % 2) ? 3 : 2, l[1], 0, 1, 0, l[0], l[2], l * 5, 0, 0, "R3");
    for (int h = 0; h < 16; h++)
      runAccess(2, 2, h, 0, h[0], 0, 1, 0, 1, 0, 200 - h, 0, 0, "R5");
    for (int r = 0; r < 8; r++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          runAccess(1, 2, 1, r, w[0], 0, 1, d[0], d[0], w[0], r * 16 + w, 0, 0,
                    ((r == 1) || (r > 5)) ? "R10 reserved region" : "R6 R7");
    for (int wn = 1; wn < 6; wn++)
      runAccess(2, 4, 1, 3, wn[0], 0, 1, 0, 0, 1, 33 + wn, wn, 0, "R4");
    runAccess(1, 0, 0, 4, 1, 0, 1, 1, 0, 0, 9, 7, 0, "R4");
    // write protect: write rejected, read allowed
    runAccess(3, 3, 3, 0, 1, 1, 1, 0, 0, 0, 77, 0, 0, "R8 protected write");
    runAccess(3, 3, 3, 0, 0, 1, 1, 0, 0, 0, 78, 0, 0, "R8");
    // invalid window
    runAccess(3, 3, 3, 0, 0, 0, 0, 0, 0, 0, 79, 0, 0, "R9 invalid window");
    runAccess(3, 3, 3, 3, 1, 0, 0, 0, 0, 0, 80, 0, 0, "R9 invalid window");
    // reserved setup
    runAccess(0, 3, 3, 0, 0, 0, 1, 0, 0, 0, 81, 0, 0, "R10 reserved setup");
    runAccess(0, 3, 3, 3, 1, 0, 1, 0, 0, 0, 82, 0, 0, "R10 reserved setup");
    // request during access
    runAccess(2, 8, 3, 0, 1, 0, 1, 0, 1, 1, 90, 0, 1, "R12");
    runAccess(1, 5, 0, 3, 0, 0, 1, 0, 0, 0, 91, 2, 1, "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule